// File: doc/BRIEF.md
# Serial DAC Write Interface Slave

This block is the digital front end of a 12-bit voltage-output converter. A host writes to it over a three-wire serial link: an active-low frame select, a serial clock and a data line. The three pins are brought into the block's own faster clock through two-flop synchronizers. The serial clock's falling edges are detected on the synchronized copy. Each detected edge shifts one data bit into the frame, most significant bit first.

When the sixteenth bit of a frame arrives, the block writes the payload into its registers. The lower twelve bits become the converter code. Bits 13:12 become the power mode. The two leading bits of the frame carry no meaning and are dropped.

The power mode drives four select lines toward the analog section. One line enables the bias, amplifier and resistor string. The other three choose between a 5 kΩ pull-down, a 100 kΩ pull-down and a floating output. If the frame select returns high before the sixteenth edge, the frame is thrown away.

Top module: `dacw_serial_front`

## Requirements
- R1: After reset, the code is 0 and the mode is 00. `core_en` is 1, the three power-down selects are 0 and `update_pulse` is 0.
- R2: After the 16th detected falling edge of `sclk` with `sync_n` low, `dac_code` takes the bits sent in positions 11..0 and `pwr_mode` takes the bits in positions 13..12. Bits are sent most significant first, so frame bit 15 goes out first.
- R3: Frame bits 15 and 14 have no effect on `dac_code`, `pwr_mode` or the select outputs.
- R4: Exactly one of the four selects is high at all times, decoded from `pwr_mode` as follows:
  - 00 gives `core_en`.
  - 01 gives `pd_pull_5k`.
  - 10 gives `pd_pull_100k`.
  - 11 gives `pd_float`.
- R5: If `sync_n` rises after 0 to 15 falling edges, `dac_code` and `pwr_mode` keep their values and no `update_pulse` is produced.
- R6: Falling edges of `sclk` after the 16th, while `sync_n` stays low, change nothing.
- R7: A falling edge of `sync_n` starts a new frame with an empty shift register, even if the previous frame was aborted. Only the bits of the new frame decide the result.
- R8: `update_pulse` is high for exactly one clock cycle per committed frame. It is high in the same cycle in which `dac_code` and `pwr_mode` take their new values.
- R9: The commit happens on the 16th edge, whether `sync_n` stays low afterwards or returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock; data is sampled on its falling edge |
| sdin | input | 1 | Serial data, most significant bit first |
| dac_code | output | 12 | Current converter code |
| pwr_mode | output | 2 | Current power mode field |
| core_en | output | 1 | Enable for the bias, amplifier and resistor string |
| pd_pull_5k | output | 1 | Select for the 5 kΩ pull-down |
| pd_pull_100k | output | 1 | Select for the 100 kΩ pull-down |
| pd_float | output | 1 | Select for the high-impedance output |
| update_pulse | output | 1 | One-cycle flag on each committed frame |

## Verification
The checker watches several properties on every cycle:
- The four selects stay one-hot and match the mode.
- Code and mode change only in a cycle flagged by `update_pulse`, and that flag lasts a single cycle.
- Each internal commit is followed by the flag and by the frame being closed.
- A high frame select closes any open frame.

Other behaviour can only be shown by the bench's scenarios:
- The bit ordering and the dropping of the two leading bits.
- Abort after each possible partial length.
- That extra clock edges are ignored.
- That a commit happens while the frame select stays low.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

  typedef enum logic [1:0] {
    PM_ACTIVE  = 2'b00,
    PM_PD_5K   = 2'b01,
    PM_PD_100K = 2'b10,
    PM_FLOAT   = 2'b11
  } pmode_t;

  // One-hot select vector {float, 100k, 5k, active} from the mode field
  function automatic logic [3:0] pd_decode(input logic [1:0] mode);
    return 4'b0001 << mode;
  endfunction

endpackage

// File: rtl/dacw_sync.sv
module dacw_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dacw_frame.sv
module dacw_frame #(
  parameter int FRAME_BITS   = 16,
  parameter int PAYLOAD_BITS = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_s,
  input  logic                    sclk_s,
  input  logic                    din_s,
  output logic                    commit,
  output logic                    armed,
  output logic [PAYLOAD_BITS-1:0] payload
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic                    sclk_d, sync_d, armed_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [PAYLOAD_BITS-2:0] shreg_q;
  logic                    sclk_fall, sync_fall, shift_en;

  assign sclk_fall = sclk_d & ~sclk_s;
  assign sync_fall = sync_d & ~sync_s;
  assign shift_en  = armed_q & ~sync_s & sclk_fall;
  assign commit    = shift_en & (cnt_q == LAST);
  // Leading don't-care bits simply fall off the top of the shorter register
  assign payload   = {shreg_q, din_s};
  assign armed     = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      sync_d  <= 1'b1;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else begin
      sclk_d <= sclk_s;
      sync_d <= sync_s;
      if (sync_s) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
        shreg_q <= '0;
      end else if (sync_fall) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
        shreg_q <= '0;
      end else if (shift_en) begin
        shreg_q <= payload[PAYLOAD_BITS-2:0];
        if (commit) begin
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dacw_regs.sv
module dacw_regs
  import dacw_pkg::*;
#(
  parameter int CODE_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit,
  input  logic [CODE_BITS+1:0] payload,
  output logic [CODE_BITS-1:0] code,
  output logic [1:0]           mode,
  output logic                 update_pulse,
  output logic [3:0]           selects
);

  logic [CODE_BITS-1:0] code_q;
  pmode_t               mode_q;
  logic                 pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      mode_q  <= PM_ACTIVE;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= commit;
      if (commit) begin
        code_q <= payload[CODE_BITS-1:0];
        mode_q <= pmode_t'(payload[CODE_BITS +: 2]);
      end
    end
  end

  assign code         = code_q;
  assign mode         = mode_q;
  assign update_pulse = pulse_q;
  assign selects      = pd_decode(mode_q);

endmodule

// File: rtl/dacw_serial_front.sv
module dacw_serial_front #(
  parameter int FRAME_BITS  = 16,
  parameter int CODE_BITS   = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_n,
  input  logic                 sclk,
  input  logic                 sdin,
  output logic [CODE_BITS-1:0] dac_code,
  output logic [1:0]           pwr_mode,
  output logic                 core_en,
  output logic                 pd_pull_5k,
  output logic                 pd_pull_100k,
  output logic                 pd_float,
  output logic                 update_pulse
);

  localparam int PAYLOAD_BITS = CODE_BITS + 2;

  logic [2:0]              pins_s;
  logic                    sync_s, sclk_s, din_s;
  logic                    commit_w, armed_w;
  logic [PAYLOAD_BITS-1:0] payload_w;
  logic [3:0]              sel_w;

  dacw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sync_n, sclk, sdin}), .q(pins_s)
  );

  assign sync_s = pins_s[2];
  assign sclk_s = pins_s[1];
  assign din_s  = pins_s[0];

  dacw_frame #(.FRAME_BITS(FRAME_BITS), .PAYLOAD_BITS(PAYLOAD_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .sync_s(sync_s), .sclk_s(sclk_s), .din_s(din_s),
    .commit(commit_w), .armed(armed_w), .payload(payload_w)
  );

  dacw_regs #(.CODE_BITS(CODE_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit_w), .payload(payload_w),
    .code(dac_code), .mode(pwr_mode), .update_pulse(update_pulse), .selects(sel_w)
  );

  assign core_en      = sel_w[0];
  assign pd_pull_5k   = sel_w[1];
  assign pd_pull_100k = sel_w[2];
  assign pd_float     = sel_w[3];

endmodule

// File: rtl/dacw_serial_front_chk.sv
module dacw_serial_front_chk #(
  parameter int CODE_BITS = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sync_s,
  input logic                 commit,
  input logic                 armed,
  input logic                 update_pulse,
  input logic [CODE_BITS-1:0] dac_code,
  input logic [1:0]           pwr_mode,
  input logic                 core_en,
  input logic                 pd_pull_5k,
  input logic                 pd_pull_100k,
  input logic                 pd_float
);

  a_r4_selects_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pd_float, pd_pull_100k, pd_pull_5k, core_en}) == 1);

  a_r4_float_mode: assert property (@(posedge clk) disable iff (!rst_n)
    pd_float |-> (pwr_mode == 2'b11));

  a_r5_hold_without_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !update_pulse |-> ($stable(dac_code) && $stable(pwr_mode)));

  a_r5_sync_high_closes: assert property (@(posedge clk) disable iff (!rst_n)
    sync_s |=> !armed);

  a_r6_commit_closes_frame: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !armed);

  a_r8_commit_flags: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> update_pulse);

  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse |=> !update_pulse);

endmodule

bind dacw_serial_front dacw_serial_front_chk #(.CODE_BITS(CODE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_s(sync_s), .commit(commit_w), .armed(armed_w),
  .update_pulse(update_pulse), .dac_code(dac_code), .pwr_mode(pwr_mode),
  .core_en(core_en), .pd_pull_5k(pd_pull_5k), .pd_pull_100k(pd_pull_100k),
  .pd_float(pd_float)
);

// File: tb/dacw_serial_front_bench.sv
module dacw_serial_front_bench;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_n = 1'b1;
  logic        sclk = 1'b0;
  logic        sdin = 1'b0;
  logic [11:0] dac_code;
  logic [1:0]  pwr_mode;
  logic        core_en, pd_pull_5k, pd_pull_100k, pd_float, update_pulse;

  int          n_cmp = 0;
  int          n_bad = 0;
  int          pulses = 0;
  int          exp_pulses = 0;
  logic [11:0] exp_code = '0;
  logic [1:0]  exp_mode = '0;
  bit          done = 0;

  always #2 clk = ~clk;

  dacw_serial_front u_dacw_serial_front (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
    .dac_code(dac_code), .pwr_mode(pwr_mode), .core_en(core_en),
    .pd_pull_5k(pd_pull_5k), .pd_pull_100k(pd_pull_100k), .pd_float(pd_float),
    .update_pulse(update_pulse)
  );

  always @(posedge clk) if (rst_n && update_pulse) pulses++;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected selects follow R4: mode 00/01/10/11 -> bit 0/1/2/3 of {float,100k,5k,en}
  task automatic check_all(input string req);
    check(req, "code", 32'(dac_code), 32'(exp_code));
    check(req, "mode", 32'(pwr_mode), 32'(exp_mode));
    check(req, "selects", 32'({pd_float, pd_pull_100k, pd_pull_5k, core_en}),
          32'(4'b0001 << exp_mode));
    check(req, "pulses", 32'(pulses), 32'(exp_pulses));
  endtask

  task automatic send(input logic [15:0] w, input int nfall, input int extra, input bit raise);
    sync_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nfall + extra; i++) begin
      sclk = 1'b1;
      sdin = (i < 16) ? w[15-i] : i[0];
      wait_clk(HALF);
      sclk = 1'b0;
      wait_clk(HALF);
    end
    if (raise) begin
      sync_n = 1'b1;
      sdin   = 1'b0;
      wait_clk(HALF);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_clk(10);
    rst_n = 1'b1;
    wait_clk(5);
    // R1: reset state
    check_all("R1");
    check("R1", "update_pulse", 32'(update_pulse), 32'd0);

    // R2, R3, R4: every mode, a spread of codes, varying don't-care bits
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k <= 16; k++) begin
        logic [11:0] c;
        logic [1:0]  dc;
        c  = (k == 16) ? 12'hFFF : 12'(k * 241);
        dc = 2'(k + m);
        send({dc, 2'(m), c}, 16, 0, 1);
        exp_code = c;
        exp_mode = 2'(m);
        exp_pulses++;
        check_all((dc != 2'b00) ? "R3" : "R2");
        check("R4", "core_en", 32'(core_en), 32'(m == 0));
      end
    end

    // Known state before the abort sweep
    send(16'h1A5C, 16, 0, 1);
    exp_code = 12'hA5C; exp_mode = 2'b01; exp_pulses++;
    check_all("R2");

    // R5: abort after every partial length
    for (int n = 0; n < 16; n++) begin
      send(16'hE3F0 ^ 16'(n), n, 0, 1);
      check_all("R5");
    end

    // R7: abort after 10 ones, then a clean frame must give exactly its own bits
    send(16'hFFFF, 10, 0, 1);
    send(16'h0001, 16, 0, 1);
    exp_code = 12'h001; exp_mode = 2'b00; exp_pulses++;
    check_all("R7");

    // R6: extra falling edges after the 16th are ignored
    send(16'h2C33, 16, 6, 1);
    exp_code = 12'hC33; exp_mode = 2'b10; exp_pulses++;
    check_all("R6");

    // R9: commit while sync stays low, then after it rises
    send(16'h3789, 16, 0, 0);
    wait_clk(HALF);
    exp_code = 12'h789; exp_mode = 2'b11; exp_pulses++;
    check_all("R9");
    sync_n = 1'b1;
    wait_clk(HALF);
    check_all("R9");

    // R8: one single-cycle pulse per committed frame over the whole run
    check("R8", "total pulses", 32'(pulses), 32'(exp_pulses));

    finish_run();
  end

endmodule